// File: doc/BRIEF.md
# VSYNC-Driven Text and Cursor Blink Generator

This block times the two blink effects of a character-cell display: the blinking cursor and the blinking text attribute. It has no timer of its own. It counts rising edges of the vertical sync input, so the blink speed follows the refresh rate of the display. Each blink period contains an equal number of visible and hidden frame intervals. A 6-bit rate value sets the period length. The text blink uses the same period, and a 2-bit duty code sets the part of that period during which blinking text is visible.

Software writes the rate field as half the period minus one. The period is therefore 2×(rate+1) VSYNC intervals. The block uses new field values only at a period boundary, so a period never changes length while it runs. The position counter runs as a small state machine with three states:
- `ST_LEAD`: the first interval of a period. The settings are sampled here.
- `ST_SHOW`: the rest of the cursor-visible half.
- `ST_HIDE`: the cursor-hidden half.

The transitions are:
- LEAD→SHOW on an edge when rate > 0.
- LEAD→HIDE on an edge when rate = 0.
- SHOW→HIDE on the edge that ends interval `rate`.
- HIDE→LEAD on the edge that ends interval 2·rate+1.

Every other case holds the current state.

Top module: `vsync_blink_gen`

## Requirements
- R1: While reset is active and after it is released, the period position is interval 0, and both `cursor_vis` and `text_vis` are 1.
- R2: Only a 0→1 transition of `vsync`, as seen on a clock edge, advances the position. It advances by exactly one interval. Holding `vsync` high, or holding it low, for any number of cycles causes no further change.
- R3: With rate R, the period is 2·(R+1) intervals. `cursor_vis` is 1 in intervals 0..R and 0 in intervals R+1..2R+1. After interval 2R+1 the position returns to interval 0.
- R4: Duty code 0 (`duty`=2'b00): `text_vis` equals `cursor_vis` in every interval.
- R5: Duty code 1 (2'b01): `text_vis` is 1 in intervals 0..L−1 and 0 after that, where L = max(1, floor((R+1)/2)).
- R6: Duty code 2 (2'b10): `text_vis` is 1 in the first R+1 intervals of the period and 0 in the rest.
- R7: Duty code 3 (2'b11): `text_vis` is 1 in the first floor(3·(R+1)/2) intervals of the period and 0 in the rest.
- R8: The period uses the values of `rate` and `duty` present on the edge that leaves interval 0. Changes made in any later interval do not affect the current period. They take effect from the next period.
- R9: With rate 0 the period is two intervals. `cursor_vis` alternates 1, 0 on successive edges. With duty code 1, L = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vsync | input | 1 | Vertical sync level; the rising edge counts one interval |
| rate | input | 6 | Half period minus one, in VSYNC intervals |
| duty | input | 2 | Text blink duty code: 0 full (same as cursor), 1 quarter, 2 half, 3 three quarters |
| cursor_vis | output | 1 | Cursor visible in this interval |
| text_vis | output | 1 | Blinking text visible in this interval |

## Verification
The hardest case to reach from the ports is a setting change in the middle of a period. The test has to show that the new value is ignored until the wrap and then used from the next period. The stimulus first counts edges to a known interval away from 0. It then changes both `rate` and `duty`, and walks the rest of the old period and the whole new period one edge at a time. At each interval it compares both outputs with values computed from the old settings and then from the new ones. A sweep over several rates, including the minimum and maximum, with all four duty codes, covers the rounding of L at small rates.

// File: rtl/blink_pkg.sv
package blink_pkg;
    typedef enum logic [1:0] {
        ST_LEAD = 2'd0,
        ST_SHOW = 2'd1,
        ST_HIDE = 2'd2
    } phase_e;

    localparam logic [1:0] DUTY_FULL    = 2'd0;
    localparam logic [1:0] DUTY_QUARTER = 2'd1;
    localparam logic [1:0] DUTY_HALF    = 2'd2;
    localparam logic [1:0] DUTY_THREEQ  = 2'd3;
endpackage

// File: rtl/vsync_edge_det.sv
module vsync_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic vsync,
    output logic tick
);
    logic vsync_q;

    always_ff @(posedge clk) begin
        if (!rst_n) vsync_q <= 1'b0;
        else        vsync_q <= vsync;
    end

    always_comb tick = vsync & ~vsync_q;

    // R2: a held-high level yields a single tick
    a_r2_single_tick: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/blink_phase_fsm.sv
module blink_phase_fsm
    import blink_pkg::*;
#(
    parameter int RATE_W = 6,
    parameter int DUTY_W = 2,
    localparam int CNT_W = RATE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [RATE_W-1:0] rate_in,
    input  logic [DUTY_W-1:0] duty_in,
    output logic [CNT_W-1:0]  pos_o,
    output logic [RATE_W-1:0] rate_eff,
    output logic [DUTY_W-1:0] duty_eff,
    output logic              cursor_o
);
    phase_e            state_q, state_d;
    logic [CNT_W-1:0]  pos_q, pos_d;
    logic [RATE_W-1:0] rate_q;
    logic [DUTY_W-1:0] duty_q;
    logic [CNT_W-1:0]  half_end;
    logic [CNT_W-1:0]  last_pos;

    // Settings follow the inputs during interval 0 and are frozen after it
    always_comb begin
        rate_eff = (state_q == ST_LEAD) ? rate_in : rate_q;
        duty_eff = (state_q == ST_LEAD) ? duty_in : duty_q;
        half_end = {1'b0, rate_eff};
        last_pos = {rate_eff, 1'b1};
    end

    always_comb begin
        state_d = state_q;
        pos_d   = pos_q;
        if (tick) begin
            unique case (state_q)
                ST_LEAD: begin
                    pos_d   = {{(CNT_W-1){1'b0}}, 1'b1};
                    state_d = (rate_eff == '0) ? ST_HIDE : ST_SHOW;
                end
                ST_SHOW: begin
                    pos_d = pos_q + 1'b1;
                    if (pos_q == half_end) state_d = ST_HIDE;
                end
                ST_HIDE: begin
                    if (pos_q == last_pos) begin
                        pos_d   = '0;
                        state_d = ST_LEAD;
                    end else begin
                        pos_d = pos_q + 1'b1;
                    end
                end
                default: begin
                    pos_d   = '0;
                    state_d = ST_LEAD;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LEAD;
            pos_q   <= '0;
            rate_q  <= '0;
            duty_q  <= '0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
            if (state_q == ST_LEAD) begin
                rate_q <= rate_in;
                duty_q <= duty_in;
            end
        end
    end

    always_comb begin
        pos_o    = pos_q;
        cursor_o = (state_q != ST_HIDE);
    end

    // R3: position never runs past the end of the period
    a_r3_pos_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q <= last_pos);
    // R3: hidden half lies after interval R
    a_r3_hide_after_half: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HIDE) |-> (pos_q > half_end));
    // R2: no edge, no movement
    a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(pos_q));
    // R8: latched settings frozen after interval 0
    a_r8_settings_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_LEAD) |=> ($stable(rate_q) && $stable(duty_q)));
    // R9: zero rate goes straight to the hidden half
    a_r9_rate0_hide: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && state_q == ST_LEAD && rate_eff == '0) |=> !cursor_o);
endmodule

// File: rtl/blink_duty_shaper.sv
module blink_duty_shaper
    import blink_pkg::*;
#(
    parameter int RATE_W = 6,
    parameter int DUTY_W = 2,
    localparam int CNT_W = RATE_W + 1,
    localparam int LEN_W = CNT_W + 1
) (
    input  logic [CNT_W-1:0]  pos,
    input  logic [RATE_W-1:0] rate,
    input  logic [DUTY_W-1:0] duty,
    input  logic              cursor,
    output logic              text_o
);
    logic [LEN_W-1:0] half_len;
    logic [LEN_W-1:0] quarter_len;
    logic [LEN_W-1:0] threeq_len;
    logic [LEN_W-1:0] pos_ext;

    always_comb begin
        half_len    = {2'b00, rate} + 1'b1;
        quarter_len = half_len >> 1;
        if (quarter_len == '0) quarter_len = {{(LEN_W-1){1'b0}}, 1'b1};
        threeq_len  = (half_len + (half_len << 1)) >> 1;
        pos_ext     = {1'b0, pos};
        unique case (duty[1:0])
            DUTY_FULL:    text_o = cursor;
            DUTY_QUARTER: text_o = pos_ext < quarter_len;
            DUTY_HALF:    text_o = pos_ext < half_len;
            DUTY_THREEQ:  text_o = pos_ext < threeq_len;
            default:      text_o = cursor;
        endcase
    end
endmodule

// File: rtl/vsync_blink_gen.sv
module vsync_blink_gen
    import blink_pkg::*;
#(
    parameter int RATE_W = 6,
    parameter int DUTY_W = 2,
    localparam int CNT_W = RATE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync,
    input  logic [RATE_W-1:0] rate,
    input  logic [DUTY_W-1:0] duty,
    output logic              cursor_vis,
    output logic              text_vis
);
    logic              tick;
    logic [CNT_W-1:0]  pos;
    logic [RATE_W-1:0] rate_eff;
    logic [DUTY_W-1:0] duty_eff;

    vsync_edge_det u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .vsync (vsync),
        .tick  (tick)
    );

    blink_phase_fsm #(.RATE_W(RATE_W), .DUTY_W(DUTY_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .rate_in  (rate),
        .duty_in  (duty),
        .pos_o    (pos),
        .rate_eff (rate_eff),
        .duty_eff (duty_eff),
        .cursor_o (cursor_vis)
    );

    blink_duty_shaper #(.RATE_W(RATE_W), .DUTY_W(DUTY_W)) u_shape (
        .pos    (pos),
        .rate   (rate_eff),
        .duty   (duty_eff),
        .cursor (cursor_vis),
        .text_o (text_vis)
    );

    // R1: interval 0 shows both cursor and text
    a_r1_first_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (pos == '0) |-> (cursor_vis && text_vis));
    // R4: full duty tracks the cursor across an edge
    a_r4_full_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && pos != '0 && duty_eff == DUTY_FULL) |=> (text_vis == cursor_vis));
endmodule

// File: tb/vsync_blink_gen_bench.sv
module vsync_blink_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vsync = 1'b0;
    logic [5:0] rate = '0;
    logic [1:0] duty = '0;
    logic       cursor_vis, text_vis;
    int         n_run = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    vsync_blink_gen u_vsync_blink_gen (
        .clk(clk), .rst_n(rst_n), .vsync(vsync), .rate(rate), .duty(duty),
        .cursor_vis(cursor_vis), .text_vis(text_vis)
    );

    function automatic int text_len(input int r, input int d);
        int h = r + 1;
        int l;
        case (d)
            1: begin l = h / 2; if (l < 1) l = 1; end
            2: l = h;
            3: l = (3 * h) / 2;
            default: l = h;
        endcase
        return l;
    endfunction

    task automatic check(input string req, input logic cexp, input logic texp, input int idx);
        n_run++;
        if (cursor_vis !== cexp || text_vis !== texp) begin
            n_fail++;
            $display("FAIL %s interval %0d: cursor=%b text=%b expected cursor=%b text=%b",
                     req, idx, cursor_vis, text_vis, cexp, texp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; vsync = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse(input int hold);
        @(negedge clk); vsync = 1'b1;
        repeat (hold) @(negedge clk);
        vsync = 1'b0;
        @(negedge clk);
    endtask

    // expected values for interval i of a period with rate r and duty d
    task automatic check_pos(input int r, input int d, input int i);
        logic ce, te;
        string tag;
        ce = (i <= r);
        te = (d == 0) ? ce : (i < text_len(r, d));
        case (d)
            0: tag = "R3/R4";
            1: tag = (r == 0) ? "R9/R5" : "R3/R5";
            2: tag = "R3/R6";
            default: tag = "R3/R7";
        endcase
        check(tag, ce, te, i);
    endtask

    initial begin
        int rates[7] = '{0, 1, 2, 3, 6, 17, 63};
        do_reset();
        check("R1", 1'b1, 1'b1, 0);

        // sweep rates and duty codes over a period and the next wrap
        foreach (rates[k]) begin
            for (int d = 0; d < 4; d++) begin
                rate = rates[k][5:0]; duty = d[1:0];
                do_reset();
                check("R1", 1'b1, 1'b1, 0);
                for (int i = 0; i < 2 * (rates[k] + 1); i++) begin
                    check_pos(rates[k], d, i);
                    pulse(1);
                end
                check_pos(rates[k], d, 0);
                pulse(1);
                check_pos(rates[k], d, 1);
            end
        end

        // R2: long high level and long idle low count as a single edge
        rate = 6'd0; duty = 2'd0;
        do_reset();
        pulse(6);
        check("R2", 1'b0, 1'b0, 1);
        repeat (20) @(negedge clk);
        check("R2", 1'b0, 1'b0, 1);
        pulse(1);
        check("R2", 1'b1, 1'b1, 0);

        // R8: a mid-period change waits for the boundary
        rate = 6'd1; duty = 2'd0;
        do_reset();
        pulse(1);
        rate = 6'd3; duty = 2'd1;
        check("R8", 1'b1, 1'b1, 1);
        pulse(1); check("R8", 1'b0, 1'b0, 2);
        pulse(1); check("R8", 1'b0, 1'b0, 3);
        pulse(1);
        for (int i = 0; i < 8; i++) begin
            n_run++;
            if (cursor_vis !== (i <= 3) || text_vis !== (i < 2)) begin
                n_fail++;
                $display("FAIL R8 new period interval %0d: cursor=%b text=%b expected cursor=%b text=%b",
                         i, cursor_vis, text_vis, (i <= 3), (i < 2));
            end
            pulse(1);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule